// File: doc/BRIEF.md
# Turbo LLR Stream Demultiplexer

This block sits in front of a turbo decoder and tags every soft value of an incoming frame with what it is and which bit it belongs to. A frame for a block of K information bits arrives as one serial stream of 3K+12 soft values. The first 3K come in groups of three per bit: systematic, then parity, then interleaved parity. Twelve tail values follow. The first six alternate systematic and parity for tail bits K, K+1 and K+2. The last six alternate interleaved systematic and interleaved parity for the same three indices.

The input is a valid/ready stream with a last marker. K is taken from `k_i` on the first sample of each frame. The output is a valid/ready stream that carries the soft value unchanged, together with a role code, an index and an error flag. The block does no decoding, buffering or interleaver addressing. Downstream logic uses the tags to route each value into its own store.

Top module: `turbo_llr_demux`

## Requirements
- R1: In the data part of a frame, sample 3k+p (p = 0, 1, 2) is tagged with index k and role code p. Role 0 is systematic, 1 is parity and 2 is interleaved parity. Bit 2 of the role code is 0 for data samples, and code 3 never appears on a data sample.
- R2: Tail samples 3K+t for t = 0..5 carry role bit 2 set. Even t gets code 4 (systematic) and odd t gets code 5 (parity). The index is K + t/2.
- R3: Tail samples 3K+t for t = 6..11 carry role bit 2 set. Even t gets code 7 (interleaved systematic) and odd t gets code 6 (interleaved parity). The index is K + (t-6)/2.
- R4: A frame with an accepted K holds 3K+12 samples. K is sampled only on the first sample, and `k_i` is ignored for the rest of the frame. The sample after a frame ends starts a new frame at index 0.
- R5: When the latched K lies outside 40..6144, every sample of that frame has the error flag set. Such a frame ends only on the last marker, and its role and index tags are not defined.
- R6: A last marker on any sample other than 3K+11 sets the error flag on that sample and ends the frame there.
- R7: A sample at position 3K+11 without the last marker has the error flag set. The frame still ends there.
- R8: Under output backpressure, no sample is lost or duplicated. A pending output holds its values stable, and the input is not ready while the output is stalled.
- R9: While reset is held, the output is not valid and the input is ready.
- R10: A sample accepted at a clock edge is presented as valid at the output right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample valid |
| in_ready_o | output | 1 | Input sample accepted when high together with valid |
| in_llr_i | input | LLR_W | Soft value |
| in_last_i | input | 1 | Marks the final sample of a frame |
| k_i | input | K_W | Information block length, sampled on the first sample of a frame |
| out_valid_o | output | 1 | Output sample valid |
| out_ready_i | input | 1 | Downstream ready |
| out_llr_o | output | LLR_W | Soft value, unchanged |
| out_role_o | output | 3 | Role code: bit 2 marks tail, bits 1:0 select the kind |
| out_idx_o | output | K_W | Bit index |
| out_err_o | output | 1 | Frame error on this sample |

## Verification
All tags have a latency of one register. A sample accepted at a rising edge appears at the output right after that edge. The bench drives inputs just after the rising edge and samples everything on the falling edge, so a handshake seen on one falling edge must show up as a valid output on the next falling edge. Expected tags are queued from a position-counting model at the input handshake and popped at the output handshake. This keeps every comparison aligned to its sample even when random backpressure stretches the delay.

// File: rtl/turbo_llr_pkg.sv
package turbo_llr_pkg;
  typedef enum logic [1:0] {
    KIND_SYS  = 2'd0,
    KIND_PAR  = 2'd1,
    KIND_IPAR = 2'd2,
    KIND_ISYS = 2'd3
  } kind_e;

  typedef struct packed {
    logic  tail;
    kind_e kind;
  } role_t;

  localparam int unsigned TAIL_LEN = 12;
endpackage

// File: rtl/llr_frame_tracker.sv
module llr_frame_tracker #(
  parameter int unsigned K_W   = 13,
  parameter int unsigned K_MIN = 40,
  parameter int unsigned K_MAX = 6144
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           adv_i,
  input  logic           last_i,
  input  logic [K_W-1:0] k_i,
  output logic [K_W-1:0] cur_k_o,
  output logic           cur_tail_o,
  output logic [1:0]     cur_phase_o,
  output logic [K_W-1:0] cur_bit_o,
  output logic [3:0]     cur_tpos_o,
  output logic           err_o
);
  localparam logic [3:0] TPOS_LAST = 4'(turbo_llr_pkg::TAIL_LEN - 1);

  logic           busy_q, bad_q, tail_q;
  logic [K_W-1:0] k_q, bit_q;
  logic [1:0]     phase_q;
  logic [3:0]     tpos_q;

  logic first, cur_bad, fin, data_end, end_frame;

  assign first       = !busy_q;
  assign cur_k_o     = first ? k_i : k_q;
  assign cur_bad     = first ? ((k_i < K_W'(K_MIN)) || (k_i > K_W'(K_MAX))) : bad_q;
  assign cur_tail_o  = first ? 1'b0 : tail_q;
  assign cur_phase_o = first ? 2'd0 : phase_q;
  assign cur_bit_o   = first ? '0 : bit_q;
  assign cur_tpos_o  = first ? 4'd0 : tpos_q;

  assign fin       = cur_tail_o && (cur_tpos_o == TPOS_LAST);
  assign data_end  = !cur_tail_o && (cur_phase_o == 2'd2) &&
                     (({1'b0, cur_bit_o} + 1'b1) == {1'b0, cur_k_o});
  assign end_frame = last_i || (!cur_bad && fin);
  assign err_o     = cur_bad || (last_i != fin);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      bad_q   <= 1'b0;
      tail_q  <= 1'b0;
      k_q     <= '0;
      bit_q   <= '0;
      phase_q <= 2'd0;
      tpos_q  <= 4'd0;
    end else if (adv_i) begin
      if (end_frame) begin
        busy_q <= 1'b0;
      end else begin
        busy_q <= 1'b1;
        k_q    <= cur_k_o;
        bad_q  <= cur_bad;
        tail_q <= cur_tail_o;
        bit_q  <= cur_bit_o;
        tpos_q <= cur_tpos_o;
        if (cur_tail_o) begin
          tpos_q  <= cur_tpos_o + 4'd1;
          phase_q <= 2'd0;
        end else if (cur_phase_o == 2'd2) begin
          phase_q <= 2'd0;
          if (data_end) begin
            tail_q <= 1'b1;
            tpos_q <= 4'd0;
          end else begin
            bit_q <= cur_bit_o + 1'b1;
          end
        end else begin
          phase_q <= cur_phase_o + 2'd1;
        end
      end
    end
  end

  AST_PHASE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !tail_q |-> phase_q != 2'd3); // R1
  AST_BIT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !bad_q && !tail_q |-> bit_q < k_q); // R4
  AST_TPOS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !bad_q && tail_q |-> tpos_q <= TPOS_LAST); // R4
  AST_K_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && $past(busy_q) |-> $stable(k_q)); // R4
endmodule

// File: rtl/llr_role_decode.sv
module llr_role_decode #(
  parameter int unsigned K_W = 13
) (
  input  logic                 tail_i,
  input  logic [1:0]           phase_i,
  input  logic [3:0]           tpos_i,
  input  logic [K_W-1:0]       k_i,
  input  logic [K_W-1:0]       bit_i,
  output turbo_llr_pkg::role_t role_o,
  output logic [K_W-1:0]       idx_o
);
  import turbo_llr_pkg::*;

  logic       second_half;
  logic [3:0] toff;
  logic [1:0] j;

  assign second_half = (tpos_i >= 4'd6);
  assign toff        = second_half ? (tpos_i - 4'd6) : tpos_i;
  assign j           = toff[2:1];

  always_comb begin
    role_o.tail = tail_i;
    if (tail_i) begin
      if (second_half) role_o.kind = tpos_i[0] ? KIND_IPAR : KIND_ISYS;
      else             role_o.kind = tpos_i[0] ? KIND_PAR  : KIND_SYS;
      idx_o = k_i + K_W'(j);
    end else begin
      case (phase_i)
        2'd0:    role_o.kind = KIND_SYS;
        2'd1:    role_o.kind = KIND_PAR;
        default: role_o.kind = KIND_IPAR;
      endcase
      idx_o = bit_i;
    end
  end
endmodule

// File: rtl/llr_out_stage.sv
module llr_out_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  output logic         ready_o,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  input  logic         ready_i,
  output logic [W-1:0] data_o
);
  assign ready_o = !valid_o || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (ready_o) begin
      valid_o <= valid_i;
      if (valid_i) data_o <= data_i;
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(data_o)); // R8
endmodule

// File: rtl/turbo_llr_demux.sv
module turbo_llr_demux #(
  parameter int unsigned LLR_W = 8,
  parameter int unsigned K_W   = 13,
  parameter int unsigned K_MIN = 40,
  parameter int unsigned K_MAX = 6144
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [LLR_W-1:0] in_llr_i,
  input  logic             in_last_i,
  input  logic [K_W-1:0]   k_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [LLR_W-1:0] out_llr_o,
  output logic [2:0]       out_role_o,
  output logic [K_W-1:0]   out_idx_o,
  output logic             out_err_o
);
  import turbo_llr_pkg::*;

  localparam int unsigned PAY_W = LLR_W + 3 + K_W + 1;

  logic           adv, err, tail;
  logic [K_W-1:0] cur_k, cur_bit, idx;
  logic [1:0]     phase;
  logic [3:0]     tpos;
  role_t          role;
  logic [PAY_W-1:0] pay_in, pay_out;

  assign adv = in_valid_i && in_ready_o;

  llr_frame_tracker #(.K_W(K_W), .K_MIN(K_MIN), .K_MAX(K_MAX)) u_trk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (adv),
    .last_i     (in_last_i),
    .k_i        (k_i),
    .cur_k_o    (cur_k),
    .cur_tail_o (tail),
    .cur_phase_o(phase),
    .cur_bit_o  (cur_bit),
    .cur_tpos_o (tpos),
    .err_o      (err)
  );

  llr_role_decode #(.K_W(K_W)) u_dec (
    .tail_i (tail),
    .phase_i(phase),
    .tpos_i (tpos),
    .k_i    (cur_k),
    .bit_i  (cur_bit),
    .role_o (role),
    .idx_o  (idx)
  );

  assign pay_in = {in_llr_i, role, idx, err};

  llr_out_stage #(.W(PAY_W)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(in_valid_i),
    .ready_o(in_ready_o),
    .data_i (pay_in),
    .valid_o(out_valid_o),
    .ready_i(out_ready_i),
    .data_o (pay_out)
  );

  assign {out_llr_o, out_role_o, out_idx_o, out_err_o} = pay_out;

  AST_DATA_NOT_ISYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_role_o[2] && !out_err_o |-> out_role_o[1:0] != 2'd3); // R1
  AST_STALL_BLOCKS_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o); // R8
  AST_ACCEPT_SHOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o && out_llr_o == $past(in_llr_i)); // R10
endmodule

// File: tb/tb_turbo_llr_demux.sv
module tb_turbo_llr_demux;
  localparam int CLK_PERIOD = 10;
  localparam int LLR_W = 8;
  localparam int K_W = 13;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_last = 1'b0;
  logic [LLR_W-1:0] in_llr = '0;
  logic [K_W-1:0] k_in = '0;
  logic out_valid, out_ready = 1'b1, out_err;
  logic [LLR_W-1:0] out_llr;
  logic [2:0] out_role;
  logic [K_W-1:0] out_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  turbo_llr_demux dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_llr_i(in_llr),
    .in_last_i(in_last), .k_i(k_in),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_llr_o(out_llr),
    .out_role_o(out_role), .out_idx_o(out_idx), .out_err_o(out_err)
  );

  typedef struct {
    int    llr;
    int    role;
    int    idx;
    int    err;
    bit    badk;
    string req;
    string ereq;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0, stall = 0, prev_acc = 0;
  bit m_busy = 0, m_bad = 0;
  int m_k = 0, m_pos = 0, frame_no = 0;

  task automatic chk(bit ok, string req, int act, int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp_v, $time);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    #1;
    out_ready = stall ? ($urandom_range(0, 3) != 0) : 1'b1;
  end

  always @(negedge clk) if (rst_n) begin
    if (prev_acc) chk(out_valid == 1'b1, "R10", int'(out_valid), 1);
    if (out_valid && out_ready) begin
      if (q.size() == 0) chk(1'b0, "R8", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(int'(out_llr) == e.llr, "R8", int'(out_llr), e.llr);
        chk(int'(out_err) == e.err, e.ereq, int'(out_err), e.err);
        if (!e.badk) begin
          chk(int'(out_role) == e.role, e.req, int'(out_role), e.role);
          chk(int'(out_idx) == e.idx, e.req, int'(out_idx), e.idx);
        end
      end
    end
    prev_acc = in_valid && in_ready;
    if (prev_acc) begin
      exp_t e;
      bit fin, en;
      int t;
      if (!m_busy) begin
        m_k = int'(k_in);
        m_bad = (m_k < 40) || (m_k > 6144);
        m_pos = 0;
      end
      e.llr = int'(in_llr);
      e.badk = m_bad;
      if (m_pos < 3*m_k) begin
        e.idx = m_pos / 3; e.role = m_pos % 3; e.req = "R1";
      end else begin
        t = m_pos - 3*m_k;
        if (t < 6) begin
          e.role = 4 + (t % 2); e.idx = m_k + t/2; e.req = "R2";
        end else begin
          e.role = ((t % 2) != 0) ? 6 : 7; e.idx = m_k + (t-6)/2; e.req = "R3";
        end
      end
      if (m_pos == 0 && frame_no > 0) e.req = "R4";
      fin = (m_pos == 3*m_k + 11);
      e.err = (m_bad || (in_last != fin)) ? 1 : 0;
      e.ereq = m_bad ? "R5" : (in_last && !fin) ? "R6" : (!in_last && fin) ? "R7" : "R4";
      q.push_back(e);
      en = in_last || (!m_bad && fin);
      if (en) begin m_busy = 0; frame_no++; end
      else begin m_busy = 1; m_pos++; end
    end
  end

  task automatic send_frame(int k, int n, int last_at);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      in_llr = LLR_W'($urandom);
      in_last = (i == last_at);
      k_in = (i == 0) ? K_W'(k) : K_W'($urandom_range(0, 8191));
      do @(negedge clk); while (!in_ready);
      @(posedge clk);
      #1;
    end
    in_valid = 1'b0;
    in_last = 1'b0;
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R9", int'(out_valid), 0);
      chk(in_ready == 1'b1, "R9", int'(in_ready), 1);
    end
    @(posedge clk); #1; rst_n = 1'b1;
    repeat (2) @(posedge clk); #1;

    stall = 0; send_frame(40, 132, 131);
    stall = 1; send_frame(41, 135, 134);
    stall = 0;
    send_frame(39, 10, 9);
    send_frame(6145, 8, 7);
    send_frame(0, 5, 4);
    send_frame(40, 50, 49);
    send_frame(40, 132, -1);
    send_frame(45, 147, 146);
    stall = 1; send_frame(6144, 18444, 18443);
    send_frame(40, 132, 131);
    stall = 0;

    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(q.size() == 0, "R8", q.size(), 0);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule